// File: doc/BRIEF.md
# Slot Configuration ROM Prober

At startup this block walks bus slots 0 through 15 in ascending order. For each slot it reads identification bytes from the top of that slot's 16 MB window. It keeps a small per-slot summary: a presence bit, the ROM flag byte, the resource-type byte and the 24-bit diagnostic-code offset. Once every slot has been probed, it elects the boot master, which is the lowest-numbered present slot whose flag byte marks it as a master candidate. It then raises a one-cycle done pulse together with the election result.

The block reads memory through a request/response port. A request carries a 32-bit byte address and uses valid/ready. The prober raises `rd_req_valid` and holds it, with a stable address, until it samples `rd_req_ready` high at a clock edge. Only one read is ever outstanding. The response channel has no back-pressure: the prober takes `rd_rsp_valid` on any cycle while it is waiting for a response. `rd_rsp_err` reports that no device answered. If no response arrives within 64 cycles of the request being accepted, the read counts as failed, and any later response to it is never tied back to it.

The ROM returns one useful byte per 32-bit word, so fields sit 4 address units apart. The stored summary of any slot can be read at any time through a combinational query port.

Top module: `slot_rom_prober`

## Requirements
- R1: Every read address is {4'hF, slot[3:0], 16'hFFFF, offset[7:0]}, with offset a multiple of 4. Slots are probed in the order 0, 1, …, 15.
- R2: The first read of each slot uses offset 0x04. The slot is present only if that read succeeds and returns 0xC3. Otherwise the slot gets no further reads and its entry reads back as not present, with flags, resource and offset all zero.
- R3: For a present slot, the prober then reads offsets 0x10 (flags), 0x00 (resource), 0x28, 0x24 and 0x20, in that order. The diagnostic offset is {byte@0x28, byte@0x24, byte@0x20}, so the higher address holds the more significant byte.
- R4: A read fails if the response carries `rd_rsp_err`, or if no response arrives within 64 cycles of acceptance. A slot that never answers therefore costs about 64 cycles.
- R5: If any read after the signature read fails, the slot is recorded as not present.
- R6: Once `rd_req_valid` is raised, it stays high and `rd_req_addr` stays stable until a cycle in which `rd_req_ready` is high.
- R7: `done` is high for exactly one cycle after the last slot has been probed. `master_valid` and `master_slot` change only in that cycle and hold their values otherwise.
- R8: The master is the lowest present slot whose flag bit 2 is 1. If there is no such slot, `master_valid` is 0 and `master_slot` is 0.
- R9: `start` begins a run and clears all entries. A `start` during a run is ignored: the run continues and produces exactly one `done`.
- R10: After reset, no request is pending, `done` and `master_valid` are 0, and every entry reads as not present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a probing run |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read byte address |
| rd_rsp_valid | input | 1 | Read response present |
| rd_rsp_err | input | 1 | No device answered |
| rd_rsp_data | input | 8 | Returned byte |
| done | output | 1 | Run finished (one cycle) |
| master_valid | output | 1 | A boot master was found |
| master_slot | output | 4 | Elected master slot |
| q_slot | input | 4 | Slot selected for summary readback |
| q_present | output | 1 | Selected slot holds a valid ROM |
| q_flags | output | 8 | Selected slot's flag byte |
| q_resource | output | 8 | Selected slot's resource-type byte |
| q_diag_off | output | 24 | Selected slot's diagnostic-code offset |

## Verification
Some properties are checked on every cycle: the address format of each request, valid and address being held while the request is back-pressured, `done` lasting a single cycle, the master outputs holding steady away from `done`, and a zero master slot whenever no master is found. Other behaviour can only be shown by the bench's scenarios. These include the presence decision on the signature byte, the byte order of the offset, timeouts and error responses causing empty slots, a mid-slot failure invalidating a slot, correct election among mixed slot populations, and a second `start` being ignored.

// File: rtl/prb_pkg.sv
package prb_pkg;
  localparam logic [7:0] SIG_BYTE   = 8'hC3;
  localparam int         CAND_BIT   = 2;
  localparam int         LAST_STEP  = 5;

  typedef struct packed {
    logic        present;
    logic [7:0]  flags;
    logic [7:0]  res;
    logic [23:0] diag;
  } slot_entry_t;

  // byte offset within the top page for each probing step
  function automatic logic [7:0] step_offset(input logic [2:0] step);
    case (step)
      3'd0:    return 8'h04;
      3'd1:    return 8'h10;
      3'd2:    return 8'h00;
      3'd3:    return 8'h28;
      3'd4:    return 8'h24;
      default: return 8'h20;
    endcase
  endfunction
endpackage

// File: rtl/prb_read_port.sv
module prb_read_port #(
  parameter int ADDR_W  = 32,
  parameter int TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [7:0]        rsp_data,
  output logic              fin,
  output logic              fin_ok,
  output logic [7:0]        fin_data
);
  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);

  typedef enum logic [1:0] {P_IDLE, P_REQ, P_WAIT} pstate_t;
  pstate_t       st;
  logic [CW-1:0] cnt;

  assign req_valid = (st == P_REQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= P_IDLE;
      cnt      <= '0;
      req_addr <= '0;
      fin      <= 1'b0;
      fin_ok   <= 1'b0;
      fin_data <= '0;
    end else begin
      fin <= 1'b0;
      case (st)
        P_IDLE: if (go) begin
          req_addr <= go_addr;
          st       <= P_REQ;
        end
        P_REQ: if (req_ready) begin
          cnt <= '0;
          st  <= P_WAIT;
        end
        default: begin
          if (rsp_valid) begin
            fin      <= 1'b1;
            fin_ok   <= !rsp_err;
            fin_data <= rsp_err ? 8'h00 : rsp_data;
            st       <= P_IDLE;
          end else if (cnt == CNT_LAST) begin
            fin      <= 1'b1;
            fin_ok   <= 1'b0;
            fin_data <= 8'h00;
            st       <= P_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/prb_slot_table.sv
module prb_slot_table
  import prb_pkg::*;
#(
  parameter int NSLOT = 16,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_idx,
  input  slot_entry_t   wr_entry,
  input  logic [SW-1:0] rd_idx,
  output slot_entry_t   rd_entry,
  output logic [NSLOT-1:0] cand
);
  slot_entry_t ent [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ent[i] <= '0;
      else if (clr)                      ent[i] <= '0;
      else if (wr_en && wr_idx == SW'(i)) ent[i] <= wr_entry;
    end
    assign cand[i] = ent[i].present && ent[i].flags[CAND_BIT];
  end

  assign rd_entry = ent[rd_idx];
endmodule

// File: rtl/prb_master_elect.sv
module prb_master_elect #(
  parameter int NSLOT = 16,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic [NSLOT-1:0] cand,
  output logic             found,
  output logic [SW-1:0]    idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = SW'(i);
      end
    end
  end
endmodule

// File: rtl/slot_rom_prober.sv
module slot_rom_prober
  import prb_pkg::*;
#(
  parameter int NSLOT   = 16,
  parameter int TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [31:0] rd_req_addr,
  input  logic        rd_rsp_valid,
  input  logic        rd_rsp_err,
  input  logic [7:0]  rd_rsp_data,
  output logic        done,
  output logic        master_valid,
  output logic [3:0]  master_slot,
  input  logic [3:0]  q_slot,
  output logic        q_present,
  output logic [7:0]  q_flags,
  output logic [7:0]  q_resource,
  output logic [23:0] q_diag_off
);
  localparam int SW = $clog2(NSLOT);
  localparam logic [SW-1:0] SLOT_LAST = SW'(NSLOT - 1);

  typedef enum logic [1:0] {T_IDLE, T_ISSUE, T_WAIT, T_FIN} tstate_t;
  tstate_t     st;
  logic [SW-1:0] slot;
  logic [2:0]  step;
  slot_entry_t work, work_nx;

  logic        go, fin, fin_ok, clr;
  logic [7:0]  fin_data;
  logic [31:0] go_addr;
  logic        wr_en;
  slot_entry_t wr_entry, rd_entry;
  logic [NSLOT-1:0] cand;
  logic        el_found;
  logic [SW-1:0] el_idx;
  logic        step_ok;

  assign go      = (st == T_ISSUE);
  assign clr     = (st == T_IDLE) && start;
  assign go_addr = {4'hF, 4'(slot), 16'hFFFF, step_offset(step)};

  prb_read_port #(.ADDR_W(32), .TIMEOUT(TIMEOUT)) u_port (
    .clk(clk), .rst_n(rst_n), .go(go), .go_addr(go_addr),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready), .req_addr(rd_req_addr),
    .rsp_valid(rd_rsp_valid), .rsp_err(rd_rsp_err), .rsp_data(rd_rsp_data),
    .fin(fin), .fin_ok(fin_ok), .fin_data(fin_data)
  );

  // merge the returned byte into the working entry
  always_comb begin
    work_nx = work;
    case (step)
      3'd1:    work_nx.flags      = fin_data;
      3'd2:    work_nx.res        = fin_data;
      3'd3:    work_nx.diag[23:16] = fin_data;
      3'd4:    work_nx.diag[15:8]  = fin_data;
      3'd5:    work_nx.diag[7:0]   = fin_data;
      default: ;
    endcase
    work_nx.present = 1'b1;
  end

  assign step_ok  = fin_ok && ((step != 3'd0) || (fin_data == SIG_BYTE));
  assign wr_en    = (st == T_WAIT) && fin && (!step_ok || step == 3'(LAST_STEP));
  assign wr_entry = step_ok ? work_nx : '0;

  prb_slot_table #(.NSLOT(NSLOT)) u_table (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_idx(slot),
    .wr_entry(wr_entry), .rd_idx(SW'(q_slot)), .rd_entry(rd_entry), .cand(cand)
  );

  prb_master_elect #(.NSLOT(NSLOT)) u_elect (
    .cand(cand), .found(el_found), .idx(el_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= T_IDLE;
      slot         <= '0;
      step         <= '0;
      work         <= '0;
      done         <= 1'b0;
      master_valid <= 1'b0;
      master_slot  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        T_IDLE: if (start) begin
          slot <= '0;
          step <= '0;
          work <= '0;
          st   <= T_ISSUE;
        end
        T_ISSUE: st <= T_WAIT;
        T_WAIT: if (fin) begin
          if (step_ok && step != 3'(LAST_STEP)) begin
            work <= work_nx;
            step <= step + 1'b1;
            st   <= T_ISSUE;
          end else if (slot == SLOT_LAST) begin
            st <= T_FIN;
          end else begin
            slot <= slot + 1'b1;
            step <= '0;
            work <= '0;
            st   <= T_ISSUE;
          end
        end
        default: begin
          done         <= 1'b1;
          master_valid <= el_found;
          master_slot  <= el_found ? 4'(el_idx) : 4'h0;
          st           <= T_IDLE;
        end
      endcase
    end
  end

  assign q_present  = rd_entry.present;
  assign q_flags    = rd_entry.flags;
  assign q_resource = rd_entry.res;
  assign q_diag_off = rd_entry.diag;
endmodule

// File: rtl/slot_rom_prober_checker.sv
module slot_rom_prober_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req_valid,
  input logic        rd_req_ready,
  input logic [31:0] rd_req_addr,
  input logic        done,
  input logic        master_valid,
  input logic [3:0]  master_slot
);
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  a_r1_addr_form: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_addr[31:28] == 4'hF) &&
                     (rd_req_addr[23:8] == 16'hFFFF) &&
                     (rd_req_addr[1:0] == 2'b00));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_master_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(master_valid) && $stable(master_slot));

  a_r8_no_master_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done && !master_valid |-> master_slot == 4'h0);
endmodule

bind slot_rom_prober slot_rom_prober_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr), .done(done),
  .master_valid(master_valid), .master_slot(master_slot)
);

// File: tb/slot_rom_prober_test.sv
module slot_rom_prober_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic rd_req_valid, rd_req_ready = 1'b1;
  logic [31:0] rd_req_addr;
  logic rd_rsp_valid = 1'b0, rd_rsp_err = 1'b0;
  logic [7:0] rd_rsp_data = 8'h00;
  logic done, master_valid;
  logic [3:0] master_slot;
  logic [3:0] q_slot = 4'h0;
  logic q_present;
  logic [7:0] q_flags, q_resource;
  logic [23:0] q_diag_off;

  always #10 clk = ~clk;

  slot_rom_prober uut (.*);

  int checks = 0, fails = 0, cyc = 0, nreads = 0, ndone = 0;
  logic [15:0] pres_m = 0, cand_m = 0, sil_m = 0, err_m = 0, mid_m = 0;
  logic stall_en = 1'b0;
  logic pend = 1'b0, pend_err = 1'b0;
  logic [7:0] pend_data = 8'h00;
  int pend_cnt = 0;

  // {present, candidate, silent, error, exp_valid, exp_slot}
  localparam logic [68:0] VEC [4] = '{
    {16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'h0},
    {16'hA5A4, 16'h8420, 16'h0000, 16'h0001, 1'b1, 4'h5},
    {16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'h0},
    {16'h0F0F, 16'h0048, 16'h0030, 16'h0000, 1'b1, 4'h3}
  };

  function automatic logic [7:0] rom_byte(input logic [3:0] s, input logic [7:0] off);
    case (off)
      8'h04:   return 8'hC3;
      8'h10:   return cand_m[s] ? 8'h05 : 8'h01;
      8'h00:   return {4'h5, s};
      8'h28:   return {s, 4'hA};
      8'h24:   return 8'h5C ^ {4'h0, s};
      8'h20:   return 8'h3E + {4'h0, s};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [23:0] exp_diag(input logic [3:0] s);
    return {s, 4'hA, 8'h5C ^ {4'h0, s}, 8'h3E + {4'h0, s}};
  endfunction

  function automatic int exp_reads();
    int n = 0;
    for (int s = 0; s < 16; s++) begin
      if (sil_m[s] || err_m[s] || !pres_m[s]) n += 1;
      else if (mid_m[s]) n += 2;
      else n += 6;
    end
    return n;
  endfunction

  // memory responder, driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (done) ndone++;
    if (rd_rsp_valid) begin
      rd_rsp_valid = 1'b0;
      rd_rsp_err   = 1'b0;
    end else if (pend) begin
      if (pend_cnt == 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_err   = pend_err;
        rd_rsp_data  = pend_data;
        pend = 1'b0;
      end else pend_cnt--;
    end
    rd_req_ready = stall_en ? ~rd_req_ready : 1'b1;
    if (rd_req_valid && rd_req_ready) begin
      logic [3:0] s;
      logic [7:0] off;
      s   = rd_req_addr[27:24];
      off = rd_req_addr[7:0];
      nreads++;
      if (!(sil_m[s] || (mid_m[s] && off != 8'h04))) begin
        pend      = 1'b1;
        pend_cnt  = 1;
        pend_err  = err_m[s];
        pend_data = err_m[s] ? 8'h00 : (pres_m[s] ? rom_byte(s, off) : 8'hFF);
      end
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk); n++;
    end
    check("R7 done reached", {31'h0, done}, 32'h1);
  endtask

  task automatic check_slots(input string tag);
    for (int s = 0; s < 16; s++) begin
      logic ep;
      ep = pres_m[s] && !sil_m[s] && !err_m[s] && !mid_m[s];
      q_slot = 4'(s); #1;
      check({tag, " present"}, {31'h0, q_present}, {31'h0, ep});
      if (ep) begin
        check("R3 flags", {24'h0, q_flags}, {24'h0, rom_byte(4'(s), 8'h10)});
        check("R3 resource", {24'h0, q_resource}, {24'h0, rom_byte(4'(s), 8'h00)});
        check("R3 diag offset", {8'h0, q_diag_off}, {8'h0, exp_diag(4'(s))});
      end else begin
        check("R2 empty entry", {q_flags, q_resource, q_diag_off[15:0]}, 32'h0);
      end
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 req idle", {31'h0, rd_req_valid}, 0);
    check("R10 done low", {31'h0, done}, 0);
    check("R10 master low", {31'h0, master_valid}, 0);
    q_slot = 4'h7; #1;
    check("R10 entry empty", {31'h0, q_present}, 0);

    // table-driven runs: R1 R2 R3 R6 R8
    for (int r = 0; r < 4; r++) begin
      logic ev;
      logic [3:0] es;
      {pres_m, cand_m, sil_m, err_m, ev, es} = VEC[r];
      mid_m = 0; stall_en = r[0]; nreads = 0;
      pulse_start();
      wait_done(n);
      check("R8 master valid", {31'h0, master_valid}, {31'h0, ev});
      check("R8 master slot", {28'h0, master_slot}, {28'h0, es});
      @(negedge clk);
      check("R2 read count", nreads, exp_reads());
      check_slots("R2");
    end

    // R5: failure after a good signature invalidates the slot
    pres_m = 16'h0006; cand_m = 16'h0006; sil_m = 0; err_m = 0; mid_m = 16'h0002;
    stall_en = 0; nreads = 0;
    pulse_start();
    wait_done(n);
    check("R5 master skips failed slot", {27'h0, master_valid, master_slot}, 32'h12);
    @(negedge clk);
    check("R5 read count", nreads, exp_reads());
    check_slots("R5");

    // R4: every slot silent, each read times out
    pres_m = 0; cand_m = 0; sil_m = 16'hFFFF; mid_m = 0; nreads = 0;
    pulse_start();
    wait_done(n);
    check("R4 lower time bound", {31'h0, n >= 16 * 64}, 1);
    check("R4 upper time bound", {31'h0, n <= 16 * 72}, 1);
    check("R4 no master", {31'h0, master_valid}, 0);
    check_slots("R4");
    // wait out any stray timing before next run
    repeat (4) @(negedge clk);

    // R9: second start during a run is ignored; R7 hold
    pres_m = 16'hFFFF; cand_m = 16'h8000; sil_m = 0; nreads = 0; ndone = 0;
    pulse_start();
    repeat (30) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done(n);
    repeat (200) @(negedge clk);
    check("R9 one done pulse", ndone, 1);
    check("R9 single run reads", nreads, 96);
    check("R7 master held", {27'h0, master_valid, master_slot}, 32'h1F);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule